// File: doc/BRIEF.md
# Delayed Branch Resolution Unit

This unit resolves control transfers for a 32-bit core that has one architectural delay slot. Each cycle it is given the address of the instruction being executed, the instruction word and the two source operand values. It decides whether the instruction is a taken conditional branch or an absolute jump, forms the destination address, requests a return-address write for the linking forms, and flags a reserved-instruction fault for malformed compare-with-zero branches.

A taken transfer does not steer the fetch stream at once. The unit records the destination and arms a pending-redirect state. The following executed instruction, the delay slot, still runs, and its successor address is the recorded destination, not its own address plus four. The pending state then clears. Cycles with `instr_valid` low are stalls: they leave the pending state untouched.

Top module: `bru_unit`

## Requirements
- R1: For conditional branches, the destination is (pc+4) plus the sign-extended 16-bit immediate (instr[15:0]) shifted left by two, wrapping modulo 2^32.
- R2: Opcode 2 (instr[31:26]) and opcode 3 are absolute jumps, always taken. Their destination is the top four bits of pc+4 followed by instr[25:0] shifted left by two.
- R3: Opcode 4 is taken when rs_val equals rt_val. Opcode 5 is taken when they differ.
- R4: Opcode 6 is taken when rs_val as a signed number is zero or negative. Opcode 7 is taken when it is strictly positive.
- R5: For opcodes 6 and 7, a nonzero instr[20:16] raises ri_exc. In that case br_taken and link_we stay low and no redirect is armed.
- R6: Opcode 1 selects its form by instr[20:16]. Values 0 and 16 are taken on signed rs_val below zero. Values 1 and 17 are taken on signed rs_val at or above zero. Any other value is not a transfer.
- R7: link_we requests a write of pc+8 (link_data) to register 31 (link_idx). Opcode 3 always requests it. Opcode 1 with selector 16 or 17 requests it only when taken. No other instruction requests it.
- R8: A taken transfer arms the pending state (delay_armed). next_pc is pc+4 while nothing is armed. For the next valid instruction (the slot), next_pc is the recorded destination, and the pending state clears afterwards unless the slot itself is taken.
- R9: A cycle with instr_valid low leaves delay_armed and the recorded destination unchanged.
- R10: Other opcodes, and any cycle with instr_valid low, give br_taken, link_we and ri_exc all low.
- R11: Synchronous active-high reset clears the pending state, so delay_armed reads 0 afterwards.
- R12: A taken transfer placed in a delay slot redirects the slot's successor to the earlier destination, then arms its own destination for the instruction after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction executes this cycle |
| pc | input | 32 | Address of the executing instruction |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | First source operand value |
| rt_val | input | 32 | Second source operand value |
| br_taken | output | 1 | The instruction transfers control |
| br_target | output | 32 | Destination address (meaningful when taken) |
| link_we | output | 1 | Return-address write request |
| link_idx | output | 5 | Register written by the link request (31) |
| link_data | output | 32 | Return address, pc+8 |
| ri_exc | output | 1 | Reserved-instruction fault |
| delay_armed | output | 1 | A redirect is pending for the next valid instruction |
| next_pc | output | 32 | Successor address of the executing instruction |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath and link register 31. At these values the offset sign extension, the wrap of a negative displacement past zero, and the jump region taken from pc+4 when pc sits just below a 256 MB boundary can all be reached with literal stimulus. Directed sequences then exercise arming, a stall that falls inside the slot, a transfer placed in a slot, a faulting branch that must not arm, and a reset while a redirect is pending.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam int XLEN    = 32;
    localparam int OPC_W   = 6;
    localparam int REG_W   = 5;
    localparam int IMM_W   = 16;
    localparam int IDX_W   = 26;
    localparam int REGION_W = XLEN - IDX_W - 2;

    localparam logic [OPC_W-1:0] OPC_REGIMM = 6'd1;
    localparam logic [OPC_W-1:0] OPC_JMP    = 6'd2;
    localparam logic [OPC_W-1:0] OPC_JMPL   = 6'd3;
    localparam logic [OPC_W-1:0] OPC_EQ     = 6'd4;
    localparam logic [OPC_W-1:0] OPC_NE     = 6'd5;
    localparam logic [OPC_W-1:0] OPC_LEZ    = 6'd6;
    localparam logic [OPC_W-1:0] OPC_GTZ    = 6'd7;

    localparam logic [REG_W-1:0] SEL_LTZ    = 5'd0;
    localparam logic [REG_W-1:0] SEL_GEZ    = 5'd1;
    localparam logic [REG_W-1:0] SEL_LTZ_LK = 5'd16;
    localparam logic [REG_W-1:0] SEL_GEZ_LK = 5'd17;

    typedef struct packed {
        logic            taken;
        logic [XLEN-1:0] target;
        logic            link;
        logic            ri;
    } br_res_t;

    function automatic logic [XLEN-1:0] rel_target(input logic [XLEN-1:0] cur,
                                                   input logic [IMM_W-1:0] imm);
        logic [XLEN-1:0] disp;
        disp = {{(XLEN-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
        return cur + 32'd4 + disp;
    endfunction

    function automatic logic [XLEN-1:0] abs_target(input logic [XLEN-1:0] cur,
                                                   input logic [IDX_W-1:0] idx);
        logic [XLEN-1:0] seq;
        seq = cur + 32'd4;
        return {seq[XLEN-1 -: REGION_W], idx, 2'b00};
    endfunction

endpackage

// File: rtl/bru_decode.sv
module bru_decode
    import bru_pkg::*;
(
    input  logic            instr_valid,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output br_res_t         res
);

    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] sel;
    logic [XLEN-1:0]  rel;
    logic             neg;
    logic             zero;

    assign opc  = instr[XLEN-1 -: OPC_W];
    assign sel  = instr[IMM_W +: REG_W];
    assign rel  = rel_target(pc, instr[IMM_W-1:0]);
    assign neg  = rs_val[XLEN-1];
    assign zero = (rs_val == '0);

    always_comb begin
        res = '0;
        case (opc)
            OPC_JMP: begin
                res.taken  = 1'b1;
                res.target = abs_target(pc, instr[IDX_W-1:0]);
            end
            OPC_JMPL: begin
                res.taken  = 1'b1;
                res.target = abs_target(pc, instr[IDX_W-1:0]);
                res.link   = 1'b1;
            end
            OPC_EQ: begin
                res.taken  = (rs_val == rt_val);
                res.target = rel;
            end
            OPC_NE: begin
                res.taken  = (rs_val != rt_val);
                res.target = rel;
            end
            OPC_LEZ: begin
                res.target = rel;
                if (sel != '0) res.ri    = 1'b1;
                else           res.taken = neg | zero;
            end
            OPC_GTZ: begin
                res.target = rel;
                if (sel != '0) res.ri    = 1'b1;
                else           res.taken = !neg && !zero;
            end
            OPC_REGIMM: begin
                res.target = rel;
                case (sel)
                    SEL_LTZ:    res.taken = neg;
                    SEL_GEZ:    res.taken = !neg;
                    SEL_LTZ_LK: begin res.taken = neg;  res.link = neg;  end
                    SEL_GEZ_LK: begin res.taken = !neg; res.link = !neg; end
                    default:    res.taken = 1'b0;
                endcase
            end
            default: res = '0;
        endcase
        if (!instr_valid) res = '0;
    end

endmodule

// File: rtl/bru_redirect.sv
module bru_redirect
    import bru_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_TGT = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic [XLEN-1:0] pc,
    input  logic            take,
    input  logic [XLEN-1:0] take_tgt,
    output logic            armed,
    output logic [XLEN-1:0] next_pc
);

    logic            armed_q;
    logic [XLEN-1:0] tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            tgt_q   <= RESET_TGT;
        end else if (instr_valid) begin
            armed_q <= take;
            if (take) tgt_q <= take_tgt;
        end
    end

    assign armed   = armed_q;
    assign next_pc = (instr_valid && armed_q) ? tgt_q : pc + 32'd4;

    AST_ARM_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && take) |=> armed); // R8

    AST_CLEAR_AFTER_SLOT: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && armed && !take) |=> !armed); // R8

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> ($stable(armed) && $stable(tgt_q))); // R9

    AST_SLOT_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(instr_valid && take) && instr_valid)
            |-> (next_pc == $past(take_tgt))); // R12

endmodule

// File: rtl/bru_unit.sv
module bru_unit
    import bru_pkg::*;
#(
    parameter logic [REG_W-1:0] LINK_REG = 5'd31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_valid,
    input  logic [31:0]      pc,
    input  logic [31:0]      instr,
    input  logic [31:0]      rs_val,
    input  logic [31:0]      rt_val,
    output logic             br_taken,
    output logic [31:0]      br_target,
    output logic             link_we,
    output logic [4:0]       link_idx,
    output logic [31:0]      link_data,
    output logic             ri_exc,
    output logic             delay_armed,
    output logic [31:0]      next_pc
);

    br_res_t res;

    bru_decode u_decode (
        .instr_valid (instr_valid),
        .pc          (pc),
        .instr       (instr),
        .rs_val      (rs_val),
        .rt_val      (rt_val),
        .res         (res)
    );

    bru_redirect u_redirect (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .pc          (pc),
        .take        (res.taken),
        .take_tgt    (res.target),
        .armed       (delay_armed),
        .next_pc     (next_pc)
    );

    assign br_taken  = res.taken;
    assign br_target = res.target;
    assign link_we   = res.link;
    assign ri_exc    = res.ri;
    assign link_idx  = LINK_REG;
    assign link_data = pc + 32'd8;

    AST_RI_BLOCKS_TAKE: assert property (@(posedge clk) disable iff (rst)
        ri_exc |-> (!br_taken && !link_we)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> (!br_taken && !link_we && !ri_exc)); // R10

    AST_LINK_NEEDS_TAKE: assert property (@(posedge clk) disable iff (rst)
        link_we |-> br_taken); // R7

    AST_RI_NO_ARM: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && ri_exc) |=> !delay_armed); // R5

endmodule

// File: tb/bru_unit_bench.sv
module bru_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 19;

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] instr;
        logic [31:0] rs;
        logic [31:0] rt;
        logic        taken;
        logic [31:0] target;
        logic        link;
        logic        ri;
    } vec_t;

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rsf,
                                          input logic [4:0] rtf, input logic [15:0] imm);
        return {op, rsf, rtf, imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] idx);
        return {op, idx};
    endfunction

    localparam vec_t VEC [NVEC] = '{
        '{32'h1000, enc_i(6'd4, 5'd1, 5'd2, 16'h0004), 32'd5, 32'd5, 1'b1, 32'h1014, 1'b0, 1'b0},      // R3 R1
        '{32'h1000, enc_i(6'd4, 5'd1, 5'd2, 16'h0004), 32'd5, 32'd6, 1'b0, 32'h0, 1'b0, 1'b0},         // R3
        '{32'h2000, enc_i(6'd5, 5'd1, 5'd2, 16'hFFFF), 32'd5, 32'd6, 1'b1, 32'h2000, 1'b0, 1'b0},      // R3 R1
        '{32'h2000, enc_i(6'd5, 5'd1, 5'd2, 16'hFFFF), 32'd9, 32'd9, 1'b0, 32'h0, 1'b0, 1'b0},         // R3
        '{32'h3000, enc_i(6'd6, 5'd1, 5'd0, 16'h0010), 32'd0, 32'd0, 1'b1, 32'h3044, 1'b0, 1'b0},      // R4
        '{32'h3000, enc_i(6'd6, 5'd1, 5'd0, 16'h0010), 32'd1, 32'd0, 1'b0, 32'h0, 1'b0, 1'b0},         // R4
        '{32'h3000, enc_i(6'd7, 5'd1, 5'd0, 16'h8000), 32'd1, 32'd0, 1'b1, 32'hFFFE3004, 1'b0, 1'b0},  // R4 R1 wrap
        '{32'h3000, enc_i(6'd7, 5'd1, 5'd0, 16'h8000), 32'h80000000, 32'd0, 1'b0, 32'h0, 1'b0, 1'b0},  // R4
        '{32'h3000, enc_i(6'd7, 5'd1, 5'd3, 16'h0001), 32'd1, 32'd0, 1'b0, 32'h0, 1'b0, 1'b1},         // R5
        '{32'h3000, enc_i(6'd6, 5'd1, 5'd1, 16'h0001), 32'd0, 32'd0, 1'b0, 32'h0, 1'b0, 1'b1},         // R5
        '{32'h4000, enc_i(6'd1, 5'd1, 5'd0, 16'h0002), 32'hFFFFFFFF, 32'd0, 1'b1, 32'h400C, 1'b0, 1'b0}, // R6
        '{32'h4000, enc_i(6'd1, 5'd1, 5'd1, 16'h0002), 32'd0, 32'd0, 1'b1, 32'h400C, 1'b0, 1'b0},       // R6
        '{32'h4000, enc_i(6'd1, 5'd1, 5'd16, 16'h0002), 32'hFFFFFFFF, 32'd0, 1'b1, 32'h400C, 1'b1, 1'b0}, // R6 R7
        '{32'h4000, enc_i(6'd1, 5'd1, 5'd16, 16'h0002), 32'd1, 32'd0, 1'b0, 32'h0, 1'b0, 1'b0},         // R7
        '{32'h4000, enc_i(6'd1, 5'd1, 5'd17, 16'h0002), 32'd7, 32'd0, 1'b1, 32'h400C, 1'b1, 1'b0},      // R6 R7
        '{32'hA0000000, enc_j(6'd2, 26'h0000100), 32'd0, 32'd0, 1'b1, 32'hA0000400, 1'b0, 1'b0},        // R2
        '{32'h3FFFFFFC, enc_j(6'd3, 26'h3FFFFFF), 32'd0, 32'd0, 1'b1, 32'h4FFFFFFC, 1'b1, 1'b0},        // R2 R7
        '{32'h5000, enc_i(6'd9, 5'd1, 5'd2, 16'h0004), 32'd5, 32'd5, 1'b0, 32'h0, 1'b0, 1'b0},         // R10
        '{32'h5000, enc_i(6'd1, 5'd1, 5'd5, 16'h0004), 32'hFFFFFFFF, 32'd0, 1'b0, 32'h0, 1'b0, 1'b0}   // R6 R10
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [31:0] pc, instr, rs_val, rt_val;
    logic        br_taken, link_we, ri_exc, delay_armed;
    logic [31:0] br_target, link_data, next_pc;
    logic [4:0]  link_idx;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bru_unit u_bru_unit (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .pc(pc), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .br_taken(br_taken), .br_target(br_target),
        .link_we(link_we), .link_idx(link_idx), .link_data(link_data), .ri_exc(ri_exc),
        .delay_armed(delay_armed), .next_pc(next_pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] p, input logic [31:0] w,
                         input logic [31:0] a, input logic [31:0] b);
        @(posedge clk); #1;
        instr_valid = v; pc = p; instr = w; rs_val = a; rt_val = b;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; instr_valid = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
    endtask

    localparam logic [31:0] NOP = 32'h0;

    initial begin
        rst = 1'b1; instr_valid = 1'b0; pc = '0; instr = '0; rs_val = '0; rt_val = '0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R11 reset armed", {31'b0, delay_armed}, 32'd0);
        chk("R10 idle taken", {31'b0, br_taken}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            drive(1'b1, VEC[i].pc, VEC[i].instr, VEC[i].rs, VEC[i].rt);
            chk($sformatf("R3/R4/R6 vec%0d taken", i), {31'b0, br_taken}, {31'b0, VEC[i].taken});
            if (VEC[i].taken)
                chk($sformatf("R1/R2 vec%0d target", i), br_target, VEC[i].target);
            chk($sformatf("R5 vec%0d ri", i), {31'b0, ri_exc}, {31'b0, VEC[i].ri});
            chk($sformatf("R7 vec%0d link", i), {31'b0, link_we}, {31'b0, VEC[i].link});
            if (VEC[i].link) begin
                chk($sformatf("R7 vec%0d link data", i), link_data, VEC[i].pc + 32'd8);
                chk($sformatf("R7 vec%0d link idx", i), {27'b0, link_idx}, 32'd31);
            end
        end

        do_reset();
        chk("R11 armed after reset", {31'b0, delay_armed}, 32'd0);
        drive(1'b1, 32'h100, NOP, 32'd0, 32'd0);
        chk("R8 plain next_pc", next_pc, 32'h104);

        // taken branch, stall inside slot, slot, successor
        drive(1'b1, 32'h1000, enc_i(6'd4, 5'd1, 5'd2, 16'h0004), 32'd3, 32'd3);
        chk("R8 branch own next_pc", next_pc, 32'h1004);
        drive(1'b0, 32'h1004, NOP, 32'd0, 32'd0);
        chk("R8 armed after take", {31'b0, delay_armed}, 32'd1);
        chk("R10 stall quiet", {31'b0, br_taken | link_we | ri_exc}, 32'd0);
        drive(1'b0, 32'h1004, NOP, 32'd0, 32'd0);
        chk("R9 stall keeps armed", {31'b0, delay_armed}, 32'd1);
        drive(1'b1, 32'h1004, NOP, 32'd0, 32'd0);
        chk("R9 slot redirect after stall", next_pc, 32'h1014);
        drive(1'b1, 32'h1014, NOP, 32'd0, 32'd0);
        chk("R8 cleared after slot", {31'b0, delay_armed}, 32'd0);
        chk("R8 successor next_pc", next_pc, 32'h1018);

        // transfer in the delay slot
        drive(1'b1, 32'h2000, enc_j(6'd2, 26'h0000800), 32'd0, 32'd0);
        chk("R12 jump target", br_target, 32'h2000);
        drive(1'b1, 32'h2004, enc_i(6'd4, 5'd1, 5'd2, 16'h0004), 32'd1, 32'd1);
        chk("R12 slot uses earlier target", next_pc, 32'h2000);
        drive(1'b1, 32'h2000, NOP, 32'd0, 32'd0);
        chk("R12 slot branch armed", {31'b0, delay_armed}, 32'd1);
        chk("R12 then own target", next_pc, 32'h2018);
        drive(1'b1, 32'h2018, NOP, 32'd0, 32'd0);
        chk("R12 cleared", next_pc, 32'h201C);

        // faulting branch must not arm
        drive(1'b1, 32'h3000, enc_i(6'd7, 5'd1, 5'd4, 16'h0004), 32'd5, 32'd0);
        chk("R5 ri raised", {31'b0, ri_exc}, 32'd1);
        drive(1'b1, 32'h3004, NOP, 32'd0, 32'd0);
        chk("R5 no arm after ri", {31'b0, delay_armed}, 32'd0);
        chk("R5 next_pc after ri", next_pc, 32'h3008);

        // reset while armed
        drive(1'b1, 32'h6000, enc_j(6'd3, 26'h0000010), 32'd0, 32'd0);
        do_reset();
        chk("R11 reset clears pending", {31'b0, delay_armed}, 32'd0);
        drive(1'b1, 32'h7000, NOP, 32'd0, 32'd0);
        chk("R11 next_pc after reset", next_pc, 32'h7004);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule